// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets a host bus fetch 16-bit words from a one-time-programmable fuse array. Software selects one of the array's blocks through an index register and issues a read command by writing a self-clearing bit in the mode control register. The fetch then runs for a fixed number of clock cycles while the status register shows the controller busy. When it finishes, the word lands in the read-data register and a sticky done flag is raised. That flag stays up until software writes a separate self-clearing clear bit.

A module-enable input gates the whole controller. While it is low, all status bits read zero, commands are dropped and any running fetch is abandoned. The intended software flow has six steps: enable the module, wait for standby, write the index, start the read, poll for done, then fetch the data and clear the flag. The array contents come from a parameter, and only the read path is built.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset with enable high, status reads 0x4 (standby only), read data reads 0, the index reads 0 and read timing reads the RD_CYCLES parameter (4).
- R2: Byte offsets: 0x04 read data, 0x0C block index (bits [4:0] kept, upper bits read 0), 0x10 mode control, 0x14 status, 0x24 read timing (bits [7:0]). Every other offset, including 0x00, 0x08, 0x20 and 0x28, reads 0, and writes there change nothing visible.
- R3: Mode control bit 1 starts a read and bit 2 clears read-done. Both are one-cycle commands, and the register always reads 0. Bit 0 (program start) has no effect.
- R4: Status layout: bit 1 read busy, bit 2 standby, bit 4 read done. Bits 0 and 3 and bits [31:5] read 0.
- R5: A start is accepted only while enable is high and standby is set. Read busy is then high, and standby low, for exactly T cycles after the accepting edge, where T is the timing value and 0 counts as 1.
- R6: On completion, read data holds array word i, zero-extended to 32 bits, where i is the index held when the start was accepted. Word i equals 0xA5C3 XOR ((i*0x0421) mod 2^16).
- R7: Read-done stays set until a write of mode bit 2 or a drop of enable. If a clear arrives on the same edge as a completion, the completion wins.
- R8: A start while busy is ignored. Index writes during a read do not alter the word it returns.
- R9: With enable low, status reads 0 and starts are ignored. A running read is abandoned without updating read data, and the controller returns to standby with done clear when enable comes back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mod_en | input | 1 | Module enable gate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |

## Verification
The hardest cases are the edge on which a fetch completes while a clear-done write arrives, and the drop of enable partway through a fetch. The bench sets the read timing to 2 and issues the clear write immediately after the start write, so the two land on the same edge. It also lowers enable a few cycles into a longer read and then checks that the read-data register still holds the previous word after re-enabling. A sweep over all 32 indices with timing values 0 to 3 covers the zero-as-one rule and every array word.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    localparam logic [5:0] OFS_RDATA = 6'h04;
    localparam logic [5:0] OFS_INDEX = 6'h0C;
    localparam logic [5:0] OFS_MODE  = 6'h10;
    localparam logic [5:0] OFS_STAT  = 6'h14;
    localparam logic [5:0] OFS_RTIM  = 6'h24;

    localparam int CMD_START_BIT = 1;
    localparam int CMD_CLEAR_BIT = 2;

    localparam int ST_BUSY_BIT  = 1;
    localparam int ST_STBY_BIT  = 2;
    localparam int ST_DONE_BIT  = 4;

endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
    parameter int          BLK_CNT = 32,
    parameter int          WORD_W  = 16,
    parameter logic [15:0] SEED    = 16'hA5C3,
    localparam int         IDX_W   = $clog2(BLK_CNT)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] cells [BLK_CNT];

    for (genvar g = 0; g < BLK_CNT; g++) begin : g_cell
        localparam logic [31:0] MIX = 32'(g) * 32'h0000_0421;
        assign cells[g] = WORD_W'(MIX[15:0] ^ SEED);
    end

    assign word = cells[idx];
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int WORD_W = 16,
    parameter int TIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic              clr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TIM_W-1:0]  tim,
    input  logic [WORD_W-1:0] arr_word,
    output logic [IDX_W-1:0]  arr_idx,
    output logic              busy,
    output logic              standby,
    output logic              done,
    output logic [WORD_W-1:0] data
);
    typedef struct packed {
        seq_state_e        state;
        logic [TIM_W-1:0]  cnt;
        logic [IDX_W-1:0]  cap;
        logic              done;
        logic [WORD_W-1:0] data;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      finish;

    always_comb begin
        seq_d  = seq_q;
        finish = 1'b0;
        if (!en) begin
            seq_d.state = SEQ_IDLE;
            seq_d.cnt   = '0;
            seq_d.done  = 1'b0;
        end else begin
            case (seq_q.state)
                SEQ_IDLE: begin
                    if (start) begin
                        seq_d.state = SEQ_BUSY;
                        seq_d.cnt   = (tim == '0) ? TIM_W'(1) : tim;
                        seq_d.cap   = idx;
                    end
                end
                default: begin
                    if (seq_q.cnt <= TIM_W'(1)) begin
                        seq_d.state = SEQ_IDLE;
                        seq_d.cnt   = '0;
                        seq_d.data  = arr_word;
                        seq_d.done  = 1'b1;
                        finish      = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt - TIM_W'(1);
                    end
                end
            endcase
            if (clr && !finish) begin
                seq_d.done = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, cnt: '0, cap: '0, done: 1'b0, data: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign arr_idx = seq_q.cap;
    assign busy    = en && (seq_q.state == SEQ_BUSY);
    assign standby = en && (seq_q.state == SEQ_IDLE);
    assign done    = seq_q.done;
    assign data    = seq_q.data;
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_pkg::*;
#(
    parameter int          BLK_CNT   = 32,
    parameter int          WORD_W    = 16,
    parameter int          TIM_W     = 8,
    parameter int          RD_CYCLES = 4,
    parameter logic [15:0] FUSE_SEED = 16'hA5C3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mod_en,
    input  logic        wr_en,
    input  logic [5:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int IDX_W = $clog2(BLK_CNT);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [TIM_W-1:0] tim;
    } cfg_regs_t;

    cfg_regs_t cfg_d, cfg_q;

    logic              cmd_start, cmd_clr;
    logic [IDX_W-1:0]  arr_idx;
    logic [WORD_W-1:0] arr_word;
    logic              seq_busy, seq_standby, seq_done;
    logic [WORD_W-1:0] seq_data;
    logic [31:0]       stat_word;

    assign cmd_start = wr_en && (addr == OFS_MODE) && wdata[CMD_START_BIT];
    assign cmd_clr   = wr_en && (addr == OFS_MODE) && wdata[CMD_CLEAR_BIT];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (addr == OFS_INDEX)) begin
            cfg_d.idx = wdata[IDX_W-1:0];
        end
        if (wr_en && (addr == OFS_RTIM)) begin
            cfg_d.tim = wdata[TIM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{idx: '0, tim: TIM_W'(RD_CYCLES)};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    fuse_array #(
        .BLK_CNT (BLK_CNT),
        .WORD_W  (WORD_W),
        .SEED    (FUSE_SEED)
    ) u_array (
        .idx  (arr_idx),
        .word (arr_word)
    );

    fuse_rd_seq #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W),
        .TIM_W  (TIM_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (mod_en),
        .start    (cmd_start),
        .clr      (cmd_clr),
        .idx      (cfg_q.idx),
        .tim      (cfg_q.tim),
        .arr_word (arr_word),
        .arr_idx  (arr_idx),
        .busy     (seq_busy),
        .standby  (seq_standby),
        .done     (seq_done),
        .data     (seq_data)
    );

    always_comb begin
        stat_word = '0;
        if (mod_en) begin
            stat_word[ST_BUSY_BIT] = seq_busy;
            stat_word[ST_STBY_BIT] = seq_standby;
            stat_word[ST_DONE_BIT] = seq_done;
        end
    end

    always_comb begin
        case (addr)
            OFS_RDATA: rdata = 32'(seq_data);
            OFS_INDEX: rdata = 32'(cfg_q.idx);
            OFS_STAT:  rdata = stat_word;
            OFS_RTIM:  rdata = 32'(cfg_q.tim);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk
    import fuse_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_en,
    input logic              wr_en,
    input logic [5:0]        addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              busy,
    input logic              standby,
    input logic              done,
    input logic [WORD_W-1:0] data
);
    // R5
    excl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && standby));

    // R9
    off_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && addr == OFS_STAT) |-> (rdata == 32'h0));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mod_en && !(wr_en && addr == OFS_MODE && wdata[CMD_CLEAR_BIT])) |=> done);

    // R5
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && addr == OFS_MODE && wdata[CMD_START_BIT] && standby));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(data));

    // R9
    reen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_en) |-> (standby && !busy));
endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .busy    (seq_busy),
    .standby (seq_standby),
    .done    (seq_done),
    .data    (seq_data)
);

// File: tb/test_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module test_fuse_rd_ctrl;
    localparam logic [5:0] A_DATA = 6'h04;
    localparam logic [5:0] A_IDX  = 6'h0C;
    localparam logic [5:0] A_MODE = 6'h10;
    localparam logic [5:0] A_STAT = 6'h14;
    localparam logic [5:0] A_TIM  = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = A_STAT;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    always #4 clk = ~clk;

    fuse_rd_ctrl i_fuse_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    ended = 0;
    string tag = "R1";

    int m_left, m_done, m_data, m_idx, m_tim, m_cap;

    function automatic int fuse_word(input int i);
        return ((i * 'h0421) & 'hFFFF) ^ 'hA5C3;
    endfunction

    function automatic logic [31:0] expect_rd(input logic [5:0] a);
        case (a)
            A_DATA: return 32'(m_data);
            A_IDX:  return 32'(m_idx);
            A_TIM:  return 32'(m_tim);
            A_STAT: begin
                if (!mod_en) return 32'h0;
                return 32'((m_done ? 16 : 0) + ((m_left > 0) ? 2 : 4));
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        logic fin;
        cyc++;
        if (!rst_n) begin
            m_left = 0; m_done = 0; m_data = 0; m_idx = 0; m_tim = 4; m_cap = 0;
        end else begin
            fin = 0;
            if (!mod_en) begin
                m_left = 0;
                m_done = 0;
            end else begin
                if (m_left > 0) begin
                    if (m_left == 1) begin
                        fin = 1;
                        m_data = fuse_word(m_cap);
                        m_done = 1;
                    end
                    m_left--;
                end else if (wr_en && addr == A_MODE && wdata[1]) begin
                    m_left = (m_tim == 0) ? 1 : m_tim;
                    m_cap = m_idx;
                end
                if (wr_en && addr == A_MODE && wdata[2] && !fin) m_done = 0;
            end
            if (wr_en && addr == A_IDX) m_idx = int'(wdata[4:0]);
            if (wr_en && addr == A_TIM) m_tim = int'(wdata[7:0]);
        end
        #3;
        if (rst_n && !ended) begin
            logic [31:0] e;
            e = expect_rd(addr);
            n_cmp++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", tag, addr, rdata, e);
            end
        end
        if (cyc > 50000 && !ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            report();
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = A_STAT; wdata = '0;
    endtask

    task automatic look(input logic [5:0] a, input int n);
        @(negedge clk);
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        tag = "R1";
        look(A_STAT, 2); look(A_DATA, 2); look(A_IDX, 1); look(A_TIM, 1); look(A_MODE, 1);
        // R2 decode and unused offsets
        tag = "R2";
        wr(A_IDX, 32'hFFFF_FFE7); look(A_IDX, 1);
        wr(6'h00, 32'hFFFF_FFFF); look(6'h00, 1);
        wr(6'h08, 32'hFFFF_FFFF); look(6'h08, 1);
        wr(6'h20, 32'hFFFF_FFFF); look(6'h20, 1);
        wr(6'h28, 32'hFFFF_FFFF); look(6'h28, 1);
        look(6'h3C, 1); look(A_IDX, 1); look(A_STAT, 1);
        // R3 program-start bit ignored, mode reads 0
        tag = "R3";
        wr(A_MODE, 32'h1); look(A_STAT, 2); look(A_MODE, 1);
        // R5 busy window
        tag = "R5";
        wr(A_TIM, 32'h5); wr(A_MODE, 32'h2); look(A_STAT, 7);
        // R6 fetched word (index 7)
        tag = "R6";
        look(A_DATA, 2);
        // R7 sticky done, clear, clear colliding with completion
        tag = "R7";
        look(A_STAT, 5); wr(A_MODE, 32'h4); look(A_STAT, 2);
        wr(A_TIM, 32'h2); wr(A_MODE, 32'h2); wr(A_MODE, 32'h4); look(A_STAT, 3);
        wr(A_MODE, 32'h4); look(A_STAT, 1);
        // R8 restart and index writes during a read
        tag = "R8";
        wr(A_INDEX_9(), 32'h9); wr(A_TIM, 32'h6); wr(A_MODE, 32'h2);
        wr(A_IDX, 32'h2); wr(A_MODE, 32'h2); look(A_STAT, 8); look(A_DATA, 2);
        // R9 enable gating
        tag = "R9";
        wr(A_MODE, 32'h4); wr(A_IDX, 32'h3); wr(A_MODE, 32'h2);
        @(negedge clk); mod_en = 1'b0;
        look(A_STAT, 3); wr(A_MODE, 32'h2); look(A_STAT, 3); look(A_DATA, 1);
        @(negedge clk); mod_en = 1'b1;
        look(A_STAT, 3); look(A_DATA, 1);
        // R4 R6 sweep over every index and timing 0..3
        tag = "R4 R6";
        for (int i = 0; i < 32; i++) begin
            wr(A_IDX, 32'(i)); wr(A_TIM, 32'(i % 4)); wr(A_MODE, 32'h2);
            look(A_STAT, 5); look(A_DATA, 1); wr(A_MODE, 32'h4);
        end
        look(A_STAT, 2);
        ended = 1;
        report();
    end

    function automatic logic [5:0] A_INDEX_9();
        return A_IDX;
    endfunction
endmodule